// File: doc/BRIEF.md
# Serial Clock Width-Signature Reset Detector

This block watches a slave-side serial clock line and recognises a reset request encoded purely in pulse widths. The host sends three high pulses on the clock line, separated by low gaps, with each high pulse held for a width that falls inside its own window. Widths are counted in master-clock cycles. When the third pulse has been high long enough, the block issues a one-cycle reset pulse that is equivalent to a power cycle. In the same cycle it issues a strobe that tells the neighbouring register file to load its default command word. It then raises a lockout flag that keeps host traffic away for a fixed interval.

Detection runs only while the part is strapped as a slave, chip-select is low and the data-ready flag is high. Dropping any of these conditions, or any pulse or gap outside its window, sends the detector back to waiting for a fresh first pulse. The clock line is brought into the master-clock domain through a two-flop synchroniser. All width counters saturate, so an over-long pulse can never wrap around into a valid window.

Top module: `sclk_reset_detector`

## Requirements
- R1: While and directly after rst_n is low, reset_pulse, lockout and load_defaults are all 0.
- R2: The first high pulse is accepted only when its width is strictly between 256 and 400 cycles (257 to 399). Widths of 256 and 400 abort the sequence.
- R3: Each of the two low gaps is accepted only when it lasts more than 5 cycles. A gap of exactly 5 cycles aborts the sequence.
- R4: The second high pulse is accepted only when its width is strictly between 512 and 900 cycles. Widths of 512 and 900 abort the sequence.
- R5: The reset fires when the third high pulse reaches 1024 cycles of the synchronised line. reset_pulse is high for exactly one cycle and becomes visible after the 1026th rising clock edge, counted from the first edge that samples the third pulse high. A third pulse that falls after 1023 cycles fires nothing.
- R6: A reset can only fire while slave_mode=1, cs_n=0 and drdy=1. Leaving any of these conditions for even one cycle during a sequence aborts the sequence.
- R7: After an abort, the detector waits for the next rising edge of the clock line as a new first pulse. A complete valid sequence that follows a rejected pulse still fires.
- R8: load_defaults is high in exactly the cycles where reset_pulse is high. In those cycles dflt_cmd is 32'h0000_0017. Bits [12:0] hold the decimation ratio 23. Every other field is 0, which encodes outputs off, two's complement, bipolar, most significant byte and bit first, bidirectional data pin, normal mode, gain 1, channel 1 and oversampling rate 1.
- R9: lockout rises in the same cycle as reset_pulse and stays high for exactly 59000 consecutive cycles.
- R10: While lockout is high, a complete valid sequence produces no reset_pulse.
- R11: Width counters saturate. A first pulse of 2348 cycles is rejected, although a wrapping 11-bit counter would read it as 300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all widths are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial clock line from the host, asynchronous |
| cs_n | input | 1 | Chip-select, active low |
| drdy | input | 1 | Data-ready flag; detection is allowed while it is high |
| slave_mode | input | 1 | 1 when the part is strapped as a serial slave |
| reset_pulse | output | 1 | One-cycle reset request |
| lockout | output | 1 | High while host communication is held off |
| load_defaults | output | 1 | Strobe telling the register file to load dflt_cmd |
| dflt_cmd | output | 32 | Default command word to be loaded |

## Verification
The bench drives every window edge from both sides. It sends first pulses of 256 and 400 cycles, second pulses of 512 and 900 cycles, gaps of 5 cycles and a third pulse that stops at 1023 cycles. A design whose comparisons are off by one would fire on one of these. It also checks that the fire edge lands exactly 1026 edges into the third pulse; a missing or extra synchroniser stage or a late compare moves that edge. Brief drops of chip-select or data-ready in the middle of a sequence, and a sequence sent during lockout, must all stay silent. A 2348-cycle first pulse exposes a counter that wraps instead of saturating. Lockout length is measured to the cycle, which catches a timer that is off by one.

// File: rtl/sclk_rst_pkg.sv
package sclk_rst_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_HI1,
        ST_LO1,
        ST_HI2,
        ST_LO2,
        ST_HI3
    } seq_st_e;

    // Layout of the command word handed to the register file
    typedef struct packed {
        logic [7:0]  flags;      // output enables, format, order, pin select
        logic [2:0]  mode_code;  // 0 = normal conversion
        logic [2:0]  gain_code;  // 0 = gain 1
        logic [1:0]  chan_code;  // 0 = channel 1
        logic [2:0]  rate_code;  // 0 = oversampling rate 1
        logic [12:0] decim;      // decimation ratio
    } cmd_word_t;

    localparam cmd_word_t CMD_DEFAULT = '{
        flags:     8'h00,
        mode_code: 3'd0,
        gain_code: 3'd0,
        chan_code: 2'd0,
        rate_code: 3'd0,
        decim:     13'd23
    };

endpackage

// File: rtl/sclk_line_sync.sv
module sclk_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic level_prev
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = cur_q.pipe[STAGES-1];
        if (STAGES > 1) begin
            nxt_d.pipe = {cur_q.pipe[STAGES-2:0], line_in};
        end else begin
            nxt_d.pipe = STAGES'(line_in);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign level      = cur_q.pipe[STAGES-1];
    assign level_prev = cur_q.prev;

endmodule

// File: rtl/sclk_pattern_fsm.sv
module sclk_pattern_fsm
    import sclk_rst_pkg::*;
#(
    parameter int P1_MIN  = 256,
    parameter int P1_MAX  = 400,
    parameter int GAP_MIN = 5,
    parameter int P2_MIN  = 512,
    parameter int P2_MAX  = 900,
    parameter int P3_FIRE = 1024,
    parameter int CW      = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic level_prev,
    input  logic qualify,
    output logic fire_now,
    output logic fire_q
);

    localparam logic [CW-1:0] CNT_SAT = '1;

    typedef struct packed {
        seq_st_e        st;
        logic [CW-1:0]  cnt;
        logic           fire;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic [CW-1:0] cnt_inc;
    logic          rise;

    always_comb begin
        cnt_inc   = (cur_q.cnt == CNT_SAT) ? cur_q.cnt : cur_q.cnt + 1'b1;
        rise      = level & ~level_prev;
        nxt_d     = cur_q;
        nxt_d.fire = 1'b0;
        if (!qualify) begin
            nxt_d.st  = ST_WAIT;
            nxt_d.cnt = '0;
        end else begin
            unique case (cur_q.st)
                ST_WAIT: begin
                    if (rise) begin
                        nxt_d.st  = ST_HI1;
                        nxt_d.cnt = CW'(1);
                    end
                end
                ST_HI1: begin
                    if (level) begin
                        nxt_d.cnt = cnt_inc;
                    end else if (cur_q.cnt > CW'(P1_MIN) && cur_q.cnt < CW'(P1_MAX)) begin
                        nxt_d.st  = ST_LO1;
                        nxt_d.cnt = CW'(1);
                    end else begin
                        nxt_d.st  = ST_WAIT;
                        nxt_d.cnt = '0;
                    end
                end
                ST_LO1, ST_LO2: begin
                    if (!level) begin
                        nxt_d.cnt = cnt_inc;
                    end else if (cur_q.cnt > CW'(GAP_MIN)) begin
                        nxt_d.st  = (cur_q.st == ST_LO1) ? ST_HI2 : ST_HI3;
                        nxt_d.cnt = CW'(1);
                    end else begin
                        nxt_d.st  = ST_WAIT;
                        nxt_d.cnt = '0;
                    end
                end
                ST_HI2: begin
                    if (level) begin
                        nxt_d.cnt = cnt_inc;
                    end else if (cur_q.cnt > CW'(P2_MIN) && cur_q.cnt < CW'(P2_MAX)) begin
                        nxt_d.st  = ST_LO2;
                        nxt_d.cnt = CW'(1);
                    end else begin
                        nxt_d.st  = ST_WAIT;
                        nxt_d.cnt = '0;
                    end
                end
                ST_HI3: begin
                    if (!level) begin
                        nxt_d.st  = ST_WAIT;
                        nxt_d.cnt = '0;
                    end else if (cur_q.cnt == CW'(P3_FIRE - 1)) begin
                        nxt_d.fire = 1'b1;
                        nxt_d.st   = ST_WAIT;
                        nxt_d.cnt  = '0;
                    end else begin
                        nxt_d.cnt = cnt_inc;
                    end
                end
                default: begin
                    nxt_d.st  = ST_WAIT;
                    nxt_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_WAIT, cnt: '0, fire: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fire_now = nxt_d.fire;
    assign fire_q   = cur_q.fire;

endmodule

// File: rtl/sclk_lockout_timer.sv
module sclk_lockout_timer #(
    parameter int LOCK_CYC = 59000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic strobe
);

    localparam int LW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] left;
        logic          strobe;
    } lock_t;

    lock_t cur_q, nxt_d;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.strobe = 1'b0;
        if (start) begin
            nxt_d.busy   = 1'b1;
            nxt_d.left   = LW'(LOCK_CYC - 1);
            nxt_d.strobe = 1'b1;
        end else if (cur_q.busy) begin
            if (cur_q.left == '0) begin
                nxt_d.busy = 1'b0;
            end else begin
                nxt_d.left = cur_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy   = cur_q.busy;
    assign strobe = cur_q.strobe;

endmodule

// File: rtl/sclk_reset_detector.sv
module sclk_reset_detector
    import sclk_rst_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int P1_MIN      = 256,
    parameter int P1_MAX      = 400,
    parameter int GAP_MIN     = 5,
    parameter int P2_MIN      = 512,
    parameter int P2_MAX      = 900,
    parameter int P3_FIRE     = 1024,
    parameter int P3_MAX      = 1200,
    parameter int LOCK_CYC    = 59000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_in,
    input  logic        cs_n,
    input  logic        drdy,
    input  logic        slave_mode,
    output logic        reset_pulse,
    output logic        lockout,
    output logic        load_defaults,
    output logic [31:0] dflt_cmd
);

    localparam int CNT_W = $clog2(P3_MAX + 1);

    logic lvl, lvl_prev, qualify, fire_now, fire_q;

    sclk_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (sclk_in),
        .level      (lvl),
        .level_prev (lvl_prev)
    );

    assign qualify = slave_mode & ~cs_n & drdy & ~lockout;

    sclk_pattern_fsm #(
        .P1_MIN  (P1_MIN),
        .P1_MAX  (P1_MAX),
        .GAP_MIN (GAP_MIN),
        .P2_MIN  (P2_MIN),
        .P2_MAX  (P2_MAX),
        .P3_FIRE (P3_FIRE),
        .CW      (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (lvl),
        .level_prev (lvl_prev),
        .qualify    (qualify),
        .fire_now   (fire_now),
        .fire_q     (fire_q)
    );

    sclk_lockout_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fire_now),
        .busy   (lockout),
        .strobe (load_defaults)
    );

    assign reset_pulse = fire_q;
    assign dflt_cmd    = CMD_DEFAULT;

endmodule

// File: rtl/sclk_reset_detector_sva.sv
module sclk_reset_detector_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        drdy,
    input logic        slave_mode,
    input logic        reset_pulse,
    input logic        lockout,
    input logic        load_defaults
);

    assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);

    assert_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> $past(slave_mode && !cs_n && drdy));

    assert_strobe_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> load_defaults);

    assert_pulse_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_defaults |-> reset_pulse);

    assert_lock_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> $rose(lockout));

    assert_quiet_in_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> !$past(lockout));

endmodule

bind sclk_reset_detector sclk_reset_detector_sva u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .drdy          (drdy),
    .slave_mode    (slave_mode),
    .reset_pulse   (reset_pulse),
    .lockout       (lockout),
    .load_defaults (load_defaults)
);

// File: tb/tb_sclk_reset_detector.sv
module tb_sclk_reset_detector;

    localparam int LOCK_CYC = 59000;
    localparam int FIRE_AT  = 1026;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0;
    logic        cs_n = 1'b0;
    logic        drdy = 1'b1;
    logic        slave_mode = 1'b1;
    logic        reset_pulse, lockout, load_defaults;
    logic [31:0] dflt_cmd;

    int tests = 0;
    int fails = 0;

    typedef struct {
        bit    fire;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   seen_pulses = 0;
    int   fire_n = 0;
    int   lk_run = 0;
    event seq_end_ev;

    always #5 clk = ~clk;

    sclk_reset_detector dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_in       (sclk_in),
        .cs_n          (cs_n),
        .drdy          (drdy),
        .slave_mode    (slave_mode),
        .reset_pulse   (reset_pulse),
        .lockout       (lockout),
        .load_defaults (load_defaults),
        .dflt_cmd      (dflt_cmd)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: strobe pairing, default word, lockout length
    always @(negedge clk) begin
        if (rst_n) begin
            if (reset_pulse) begin
                seen_pulses++;
                check(load_defaults == 1'b1, "R8", "load_defaults with pulse", load_defaults, 1);
                check(dflt_cmd == 32'h0000_0017, "R8", "default word", dflt_cmd, 32'h17);
                check(lockout == 1'b1, "R9", "lockout at pulse", lockout, 1);
            end else if (load_defaults) begin
                check(1'b0, "R8", "strobe without pulse", 1, 0);
            end
            if (lockout) begin
                lk_run++;
            end else if (lk_run != 0) begin
                check(lk_run == LOCK_CYC, "R9", "lockout length", lk_run, LOCK_CYC);
                lk_run = 0;
            end
        end
    end

    // Scoreboard consumer
    always @(seq_end_ev) begin
        exp_t e;
        e = exp_q.pop_front();
        check(seen_pulses == (e.fire ? 1 : 0), e.tag, "reset pulses", seen_pulses, e.fire ? 1 : 0);
        if (e.fire) begin
            check(fire_n == FIRE_AT, e.tag, "fire edge in third pulse", fire_n, FIRE_AT);
        end
    end

    task automatic hi_pulse(int w);
        sclk_in = 1'b1;
        repeat (w) @(negedge clk);
        sclk_in = 1'b0;
    endtask

    task automatic lo_gap(int g);
        repeat (g) @(negedge clk);
    endtask

    task automatic run_seq(int lead, int w1, int g1, int w2, int g2, int w3, bit fire, string tag);
        exp_t e;
        e.fire = fire;
        e.tag  = tag;
        exp_q.push_back(e);
        seen_pulses = 0;
        fire_n = 0;
        lo_gap(10);
        if (lead > 0) begin
            hi_pulse(lead);
            lo_gap(10);
        end
        hi_pulse(w1);
        lo_gap(g1);
        hi_pulse(w2);
        lo_gap(g2);
        sclk_in = 1'b1;
        for (int n = 1; n <= w3 + 4; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == w3) sclk_in = 1'b0;
            if (reset_pulse && fire_n == 0) fire_n = n;
        end
        sclk_in = 1'b0;
        lo_gap(20);
        -> seq_end_ev;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(reset_pulse == 0, "R1", "reset_pulse in reset", reset_pulse, 0);
        check(lockout == 0, "R1", "lockout in reset", lockout, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(reset_pulse == 0 && lockout == 0 && load_defaults == 0, "R1", "outputs after reset",
              {reset_pulse, lockout, load_defaults}, 0);

        run_seq(0, 256, 10, 700, 10, 1100, 0, "R2");
        run_seq(0, 400, 10, 700, 10, 1100, 0, "R2");
        run_seq(0, 300, 5, 700, 10, 1100, 0, "R3");
        run_seq(0, 300, 10, 700, 5, 1100, 0, "R3");
        run_seq(0, 300, 10, 512, 10, 1100, 0, "R4");
        run_seq(0, 300, 10, 900, 10, 1100, 0, "R4");
        run_seq(0, 300, 10, 700, 10, 1023, 0, "R5");
        run_seq(0, 2348, 10, 700, 10, 1100, 0, "R11");

        slave_mode = 1'b0;
        run_seq(0, 300, 10, 700, 10, 1100, 0, "R6");
        slave_mode = 1'b1;

        fork
            run_seq(0, 300, 10, 700, 10, 1100, 0, "R6");
            begin
                repeat (600) @(negedge clk);
                cs_n = 1'b1;
                @(negedge clk);
                cs_n = 1'b0;
            end
        join

        fork
            run_seq(0, 300, 10, 700, 10, 1100, 0, "R6");
            begin
                repeat (1300) @(negedge clk);
                drdy = 1'b0;
                @(negedge clk);
                drdy = 1'b1;
            end
        join

        // R7: rejected short pulse first, then a minimal-width valid sequence
        run_seq(100, 257, 6, 513, 6, 1100, 1, "R7");
        run_seq(0, 300, 10, 700, 10, 1100, 0, "R10");
        while (lockout) @(negedge clk);
        run_seq(0, 399, 50, 899, 50, 1100, 1, "R5");
        while (lockout) @(negedge clk);
        repeat (5) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule